// File: doc/BRIEF.md
# Packed Byte Search Unit

This execution unit treats a data word as a row of byte lanes and looks for one key byte in all lanes at once. When any lane holds the key, it returns the position of the lowest such lane as a small non-negative number. A caller can add that number to the word's base address to get the address of the matching byte. When no lane holds the key, it returns minus one. A sign test on the result therefore tells found from not-found, with no separate status bit.

A string scan loads eight bytes per step. It runs the unit once with the wanted character as the key. It runs the unit again with a zero key, which finds a terminating null inside the word. An optional flag-setting form records the sign and zero state of the result in a flags nibble, which a following conditional branch reads.

The result, its valid strobe and the flags are registered and appear one clock after the request.

Top module: `pbs_unit`

## Requirements
- R1: When at least one lane equals the key, the result is the lane index (0 to LANES-1), zero-extended to the full data width.
- R2: When no lane equals the key, the result is all ones, which is minus one in two's complement.
- R3: Lane k occupies data bits [8k+7:8k], so lane 0 is the least significant byte. When several lanes match, the lowest-numbered lane wins.
- R4: A zero key finds the lowest zero byte in the word, which is how a null terminator is detected.
- R5: The result and res_valid_o are registered. res_valid_o is high exactly in the cycle after a cycle with valid_i high, and the result changes only in that case.
- R6: The flags nibble holds a negative bit in bit 3, equal to result bit 63, and a zero bit in bit 2, set when the result equals 0. Bits 1:0 always read 0. The nibble takes these values one clock after valid_i when set_flags_i is high.
- R7: When valid_i is high with set_flags_i low, or when valid_i is low, the flags keep their previous value.
- R8: While reset is asserted, the result, res_valid_o and the flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| set_flags_i | input | 1 | Update the flags with this request |
| data_i | input | 64 | Packed byte operand |
| key_i | input | 8 | Byte to look for, taken from the low bits of the second source |
| result_o | output | 64 | Lane index, or all ones when nothing matches |
| res_valid_o | output | 1 | Result valid, one cycle after the request |
| flags_o | output | 4 | {negative, zero, 0, 0} |

## Verification
The bench builds the unit with its default sizes: a 64-bit word split into eight byte lanes. At this size every lane position, including both end lanes, can be driven directly. Directed words cover single matches, several matches at once, no match and embedded zero bytes. Random words seeded from a narrow byte alphabet then make repeated matches common, so the lowest-lane priority is exercised across many combinations of set_flags_i and valid_i.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    localparam int FLAGS_W    = 4;
    localparam int FLAG_NEG_B = 3;
    localparam int FLAG_ZER_B = 2;
endpackage

// File: rtl/pbs_lane_cmp.sv
module pbs_lane_cmp #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [LANE_W-1:0] key_i,
    output logic [LANES-1:0]  hit_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit_o[g] = (data_i[g*LANE_W +: LANE_W] == key_i);
    end
endmodule

// File: rtl/pbs_first_sel.sv
module pbs_first_sel #(
    parameter int LANES = 8,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LANES-1:0] hit_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    // R3: the chosen lane really hit, and no lower lane hit
    p_lowest_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_o |-> (hit_i[idx_o] && ((hit_i & ((LANES'(1) << idx_o) - LANES'(1))) == '0)));
    p_none_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_i == '0) |-> !any_o);
endmodule

// File: rtl/pbs_flag_gen.sv
module pbs_flag_gen
    import pbs_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]  value_i,
    output logic [FLAGS_W-1:0] flags_o
);
    always_comb begin
        flags_o             = '0;
        flags_o[FLAG_NEG_B] = value_i[DATA_W-1];
        flags_o[FLAG_ZER_B] = (value_i == '0);
    end
endmodule

// File: rtl/pbs_unit.sv
module pbs_unit
    import pbs_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                valid_i,
    input  logic                set_flags_i,
    input  logic [DATA_W-1:0]   data_i,
    input  logic [LANE_W-1:0]   key_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                res_valid_o,
    output logic [FLAGS_W-1:0]  flags_o
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        logic [DATA_W-1:0]  result;
        logic               vld;
        logic [FLAGS_W-1:0] flags;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0]   hit;
    logic               any_hit;
    logic [IDX_W-1:0]   first_idx;
    logic [DATA_W-1:0]  search_val;
    logic [FLAGS_W-1:0] new_flags;

    pbs_lane_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
        .data_i (data_i),
        .key_i  (key_i),
        .hit_o  (hit)
    );

    pbs_first_sel #(.LANES(LANES)) u_sel (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hit_i  (hit),
        .any_o  (any_hit),
        .idx_o  (first_idx)
    );

    assign search_val = any_hit ? {{(DATA_W-IDX_W){1'b0}}, first_idx} : '1;

    pbs_flag_gen #(.DATA_W(DATA_W)) u_flag (
        .value_i (search_val),
        .flags_o (new_flags)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) begin
            st_d.result = search_val;
            if (set_flags_i) begin
                st_d.flags = new_flags;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o    = st_q.result;
    assign res_valid_o = st_q.vld;
    assign flags_o     = st_q.flags;

    p_vld_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> res_valid_o);
    p_vld_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !res_valid_o);
    p_res_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(result_o));
    p_res_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |-> ((result_o == '1) || (result_o < DATA_W'(LANES))));
    p_flags_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_i && set_flags_i) |=> $stable(flags_o));
    p_flags_neg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && set_flags_i) |=> (flags_o[FLAG_NEG_B] == result_o[DATA_W-1]
                                      && flags_o[1:0] == 2'b00));
endmodule

// File: tb/pbs_unit_tb.sv
module pbs_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic        setf = 1'b0;
    logic [63:0] data = '0;
    logic [7:0]  key = '0;
    logic [63:0] result;
    logic        rvld;
    logic [3:0]  flags;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    logic [63:0] m_res = '0;
    logic        m_vld = 1'b0;
    logic [3:0]  m_flg = '0;

    always #5 clk = ~clk;

    pbs_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .set_flags_i(setf),
        .data_i(data), .key_i(key), .result_o(result), .res_valid_o(rvld),
        .flags_o(flags)
    );

    function automatic logic [63:0] ref_find(logic [63:0] d, logic [7:0] k);
        for (int b = 0; b < 8; b++) begin
            if (d[b*8 +: 8] == k) return 64'(b);
        end
        return {64{1'b1}};
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // reference model, updated on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_res <= '0; m_vld <= 1'b0; m_flg <= '0;
        end else begin
            m_vld <= valid;
            if (valid) begin
                m_res <= ref_find(data, key);
                if (setf) m_flg <= {ref_find(data, key)[63], ref_find(data, key) == 64'd0, 2'b00};
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R5 model result", result, m_res);
            check("R5 model valid", {63'd0, rvld}, {63'd0, m_vld});
            check("R6 model flags", {60'd0, flags}, {60'd0, m_flg});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // called at a negedge; issues one request and checks at the next negedge
    task automatic op(logic [63:0] d, logic [7:0] k, logic sf, string tag, logic [63:0] exp_res);
        data = d; key = k; setf = sf; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0; setf = 1'b0;
        check(tag, result, exp_res);
    endtask

    initial begin
        logic [3:0]  keep_flags;
        logic [63:0] keep_res;
        repeat (3) @(negedge clk);
        check("R8 reset result", result, 64'd0);
        check("R8 reset valid", {63'd0, rvld}, 64'd0);
        check("R8 reset flags", {60'd0, flags}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        op(64'h1122_AB44_5566_7788, 8'hAB, 1'b1, "R1 lane5", 64'd5);
        check("R6 flags pos", {60'd0, flags}, 64'h0);
        op(64'h0102_0304_0506_0708, 8'hEE, 1'b1, "R2 none", {64{1'b1}});
        check("R6 flags neg", {60'd0, flags}, 64'h8);
        op(64'h5A00_0000_005A_0000, 8'h5A, 1'b1, "R3 lowest of lanes 2,7", 64'd2);
        op(64'h7700_0000_0000_0077, 8'h77, 1'b1, "R3 lane0 wins", 64'd0);
        check("R6 flags zero", {60'd0, flags}, 64'h4);
        op(64'h99FF_FFFF_FFFF_FFFF, 8'h99, 1'b1, "R1 lane7", 64'd7);
        op(64'h4142_4344_0046_4700, 8'h00, 1'b1, "R4 null lane0", 64'd0);
        op(64'h6162_6364_0066_6768, 8'h00, 1'b1, "R4 null lane3", 64'd3);
        op(64'h6162_6364_6566_6768, 8'h00, 1'b1, "R4 no null", {64{1'b1}});
        check("R6 flags after no null", {60'd0, flags}, 64'h8);

        keep_flags = flags;
        op(64'h0000_0000_0000_1200, 8'h12, 1'b0, "R1 lane1 noflags", 64'd1);
        check("R7 flags held setf low", {60'd0, flags}, {60'd0, keep_flags});

        keep_res = result;
        data = 64'h0; key = 8'h00; setf = 1'b1; valid = 1'b0;
        @(negedge clk);
        setf = 1'b0;
        check("R5 valid low", {63'd0, rvld}, 64'd0);
        check("R5 result held", result, keep_res);
        check("R7 flags held valid low", {60'd0, flags}, {60'd0, keep_flags});

        for (int n = 0; n < 400; n++) begin
            logic [63:0] d;
            for (int b = 0; b < 8; b++) d[b*8 +: 8] = 8'($urandom_range(0, 5));
            data = d;
            key = 8'($urandom_range(0, 7));
            setf = $urandom_range(0, 1) == 1;
            valid = $urandom_range(0, 3) != 0;
            @(negedge clk);
        end
        valid = 1'b0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule